// File: doc/BRIEF.md
# Serial Command/Address Port Slave

This block is a slave port that lets a host controller reach a 64-entry byte store inside the chip over four wires. The wires are an active-low select, a serial clock, a receive line and a transmit line. Each access opens with a command/address byte, followed by one data byte. On a write, the host sends the data byte. On a read, the port shifts the data byte back out. Bits travel least significant first. The port captures a bit on each rising serial clock edge and moves its output on falling edges. Writes can be chained inside one select window. A read closes the window until the select is released.

The three serial inputs are brought into the system clock domain through two-flop synchronisers. All framing, shifting and decoding runs on the system clock, so that clock must be several times faster than the serial clock. The memory side is a plain strobe interface: an address, write data, a one-cycle write strobe and a one-cycle read strobe. It has no valid/ready pair and no back-pressure. The memory must accept every write strobe. It must also present read data combinationally from the address in the same cycle as the read strobe.

The transmit pin is modelled as a value plus an output enable. The enable is high only while read data is being returned. This lets the pad tristate the line so that it can share a wire with the receive line.

Top module: `serial_cmd_port`

## Requirements
- R1: While csn is high, the port makes no memory access and keeps txd_oe low, whatever sck and rxd do. A falling csn starts a new command/address byte.
- R2: On each rising sck edge while csn is low, one rxd bit is captured. The first bit of a byte is bit 0.
- R3: In the command byte, bit 7 is the read flag and bit 6 is the write flag. Bits 5:0 are the address.
- R4: A write command followed by 8 data bits gives exactly one mem_we pulse, one system clock long. During that pulse, mem_addr holds the command address and mem_wdata holds the received byte.
- R5: A read command gives exactly one mem_re pulse, one system clock long, with mem_addr holding the address. The fetched byte is returned on txd least significant bit first. Bit 0 is valid at the first data rising edge, and each later bit follows a falling sck edge.
- R6: txd_oe is high only during the data byte of a read. It is low after reset, during command bytes, and during write data.
- R7: After a write data byte, the next 8 bits while csn stays low form a new command byte. Chained writes therefore all reach memory.
- R8: After a read data byte, the port ignores further bits until csn goes high. It makes no access and keeps txd_oe low.
- R9: A command byte with both flags clear or both flags set consumes the following byte and makes no access. The byte after that is a new command.
- R10: If csn rises in the middle of a byte, the partial byte is discarded and no access results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn | input | 1 | Active-low select from host |
| sck | input | 1 | Serial clock from host |
| rxd | input | 1 | Serial data from host |
| txd | output | 1 | Serial read data to host |
| txd_oe | output | 1 | Output enable for the txd pad (high = drive) |
| mem_addr | output | 6 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the mem_re cycle |

## Verification
The bench chains two writes inside one select window. A port that dropped back to the data phase, or waited for csn to rise, would lose the second write. It sends a write command after a read in the same window, which a port that forgot the read lockout would carry out. It also issues commands with no flags and with both flags set, which a sloppy decoder would turn into an access. It toggles sck while csn is high and aborts a byte part-way. Either would leak a stray strobe if framing were not tied to csn. Readback of patterns with distinct bit values shows any bit-order or off-by-one shift error on txd.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 2;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int RD_BIT = BYTE_W - 1;
  localparam int WR_BIT = BYTE_W - 2;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP,
    PH_HOLD
  } phase_t;
endpackage

// File: rtl/smp_sync.sv
module smp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/smp_engine.sv
module smp_engine
  import smp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              rxd_s,
  input  logic              rise,
  output phase_t            phase,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata,
  output logic              we,
  output logic              re
);
  logic [BYTE_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] byte_in;
  logic              last_bit;

  assign byte_in  = {rxd_s, sr[BYTE_W-1:1]};
  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      sr    <= '0;
      addr  <= '0;
      wdata <= '0;
      we    <= 1'b0;
      re    <= 1'b0;
    end else begin
      we <= 1'b0;
      re <= 1'b0;
      if (csn_s) begin
        phase <= PH_CMD;
        cnt   <= '0;
      end else if (rise) begin
        sr  <= byte_in;
        cnt <= cnt + 1'b1;
        if (last_bit) begin
          unique case (phase)
            PH_CMD: begin
              addr <= byte_in[ADDR_W-1:0];
              if (byte_in[RD_BIT] && !byte_in[WR_BIT]) begin
                re    <= 1'b1;
                phase <= PH_RDAT;
              end else if (byte_in[WR_BIT] && !byte_in[RD_BIT]) begin
                phase <= PH_WDAT;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_WDAT: begin
              wdata <= byte_in;
              we    <= 1'b1;
              phase <= PH_CMD;
            end
            PH_SKIP: phase <= PH_CMD;
            PH_RDAT: phase <= PH_HOLD;
            default: phase <= PH_HOLD;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smp_txd.sv
module smp_txd
  import smp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [BYTE_W-1:0] rdata,
  input  logic              rise,
  input  logic              fall,
  output logic              txd,
  output logic              txd_oe
);
  logic [BYTE_W-1:0] tx_sr;
  logic              loaded;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      loaded <= 1'b0;
      armed  <= 1'b0;
    end else if (!active) begin
      loaded <= 1'b0;
      armed  <= 1'b0;
    end else if (load) begin
      tx_sr  <= rdata;
      loaded <= 1'b1;
      armed  <= 1'b0;
    end else if (rise) begin
      armed <= 1'b1;
    end else if (fall && armed) begin
      tx_sr <= {1'b0, tx_sr[BYTE_W-1:1]};
      armed <= 1'b0;
    end
  end

  assign txd    = tx_sr[0];
  assign txd_oe = active && loaded;
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import smp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              rxd,
  output logic              txd,
  output logic              txd_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [2:0] sync_q;
  logic       csn_s, sck_s, rxd_s, sck_d;
  logic       rise, fall;
  phase_t     phase;

  smp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rxd, sck, csn}), .q(sync_q)
  );
  assign {rxd_s, sck_s, csn_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign rise = !csn_s && sck_s && !sck_d;
  assign fall = !csn_s && !sck_s && sck_d;

  smp_engine u_engine (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .rxd_s(rxd_s), .rise(rise),
    .phase(phase), .addr(mem_addr), .wdata(mem_wdata), .we(mem_we), .re(mem_re)
  );

  smp_txd u_txd (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_RDAT), .load(mem_re),
    .rdata(mem_rdata), .rise(rise), .fall(fall), .txd(txd), .txd_oe(txd_oe)
  );
endmodule

// File: rtl/serial_cmd_port_chk.sv
module serial_cmd_port_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic txd_oe,
  input logic mem_we,
  input logic mem_re
);
  a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  a_r5_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);
  a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  a_r6_oe_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe |-> !mem_we);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3) && $past(csn, 4) && $past(csn, 5))
      |-> (!txd_oe && !mem_we && !mem_re));
endmodule

bind serial_cmd_port serial_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .txd_oe(txd_oe),
  .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/test_serial_cmd_port.sv
`timescale 1ns/1ps
module test_serial_cmd_port;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, csn = 1, sck = 0, rxd = 0;
  logic txd, txd_oe, mem_we, mem_re;
  logic [5:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] bmem [64];
  logic [7:0] shadow [64];
  int errors = 0, checks = 0, we_cnt = 0, re_cnt = 0;
  logic oe_seen_all, oe_seen_any;

  always #2.5 clk = ~clk;

  serial_cmd_port i_serial_cmd_port (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .rxd(rxd),
    .txd(txd), .txd_oe(txd_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) begin bmem[mem_addr] <= mem_wdata; we_cnt <= we_cnt + 1; end
    if (mem_re) re_cnt <= re_cnt + 1;
  end

  // cmd byte, data byte; bit7 = read, bit6 = write, bits5:0 = address
  localparam logic [15:0] VEC [8] = '{
    16'h4A_A5, 16'h7F_3C, 16'h40_01, 16'h55_80,
    16'h8A_00, 16'hBF_00, 16'h80_00, 16'h95_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (H) @(negedge clk);
      r[i] = txd;
      oe_seen_all &= txd_oe;
      oe_seen_any |= txd_oe;
      sck = 1;
      repeat (H) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic sel(input logic v);
    @(negedge clk); csn = v; repeat (4 * H) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int w0, r0;
    for (int a = 0; a < 64; a++) begin
      bmem[a] = 8'(a * 7 + 3);
      shadow[a] = 8'(a * 7 + 3);
    end
    repeat (10) @(negedge clk);
    chk(!txd_oe && !mem_we && !mem_re, "R6 reset idle", txd_oe, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // vector walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] c, d;
      c = VEC[v][15:8]; d = VEC[v][7:0];
      w0 = we_cnt; r0 = re_cnt;
      sel(0);
      oe_seen_any = 0;
      send_bits(c, 8, r);
      chk(!oe_seen_any, "R6 oe low in command", oe_seen_any, 0);
      oe_seen_all = 1; oe_seen_any = 0;
      send_bits(d, 8, r);
      sel(1);
      if (c[6]) begin
        shadow[c[5:0]] = d;
        chk(we_cnt == w0 + 1, "R4 one write strobe", we_cnt - w0, 1);
        chk(bmem[c[5:0]] == d, "R2 R4 write data", bmem[c[5:0]], d);
        chk(!oe_seen_any, "R6 oe low in write data", oe_seen_any, 0);
      end else begin
        chk(re_cnt == r0 + 1, "R5 one read strobe", re_cnt - r0, 1);
        chk(r == shadow[c[5:0]], "R3 R5 read data", r, shadow[c[5:0]]);
        chk(oe_seen_all, "R6 oe high in read data", oe_seen_all, 1);
      end
    end

    // R1: sck activity while deselected
    w0 = we_cnt; r0 = re_cnt; oe_seen_any = 0;
    send_bits(8'h4C, 8, r); send_bits(8'hFF, 8, r); send_bits(8'h8C, 8, r);
    repeat (4 * H) @(negedge clk);
    chk(we_cnt == w0 && re_cnt == r0 && !oe_seen_any, "R1 ignore when deselected", we_cnt - w0, 0);
    chk(bmem[12] == shadow[12], "R1 memory untouched", bmem[12], shadow[12]);

    // R7: chained writes
    w0 = we_cnt;
    sel(0);
    send_bits(8'h50, 8, r); send_bits(8'h69, 8, r);
    send_bits(8'h51, 8, r); send_bits(8'h96, 8, r);
    sel(1);
    shadow[16] = 8'h69; shadow[17] = 8'h96;
    chk(we_cnt == w0 + 2, "R7 two chained strobes", we_cnt - w0, 2);
    chk(bmem[16] == 8'h69 && bmem[17] == 8'h96, "R7 chained data", {bmem[16], bmem[17]}, 16'h6996);

    // R8: write after read in same window is ignored
    w0 = we_cnt; r0 = re_cnt;
    sel(0);
    send_bits(8'h90, 8, r); send_bits(8'h00, 8, r);
    chk(r == 8'h69, "R8 read before lockout", r, 8'h69);
    oe_seen_any = 0;
    send_bits(8'h50, 8, r); send_bits(8'h00, 8, r);
    sel(1);
    chk(we_cnt == w0 && re_cnt == r0 + 1, "R8 no access after read", we_cnt - w0, 0);
    chk(!oe_seen_any && bmem[16] == 8'h69, "R8 oe low and memory kept", bmem[16], 8'h69);

    // R9: invalid commands then valid write in same window
    w0 = we_cnt; r0 = re_cnt;
    sel(0);
    send_bits(8'h12, 8, r); send_bits(8'h5A, 8, r);
    send_bits(8'hD2, 8, r); send_bits(8'h5A, 8, r);
    chk(we_cnt == w0 && re_cnt == r0, "R9 no access on bad command", we_cnt - w0, 0);
    send_bits(8'h53, 8, r); send_bits(8'hC3, 8, r);
    sel(1);
    shadow[19] = 8'hC3;
    chk(bmem[18] == shadow[18] && bmem[19] == 8'hC3, "R9 recovery write", bmem[19], 8'hC3);
    chk(we_cnt == w0 + 1, "R9 single strobe", we_cnt - w0, 1);

    // R10: abort mid data byte
    w0 = we_cnt;
    sel(0);
    send_bits(8'h54, 8, r); send_bits(8'hEE, 5, r);
    sel(1);
    chk(we_cnt == w0 && bmem[20] == shadow[20], "R10 aborted write", we_cnt - w0, 0);
    sel(0);
    send_bits(8'h94, 8, r); send_bits(8'h00, 8, r);
    sel(1);
    chk(r == shadow[20], "R10 command after abort", r, shadow[20]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule